// File: doc/BRIEF.md
# Transport Stream Packetizer

This block takes one elementary-stream packet at a time as a byte stream and cuts it into fixed 188-byte transport packets. All packets go out on a single stream identifier that is fixed by a parameter. Each packet holds a 4-byte header and up to 184 payload bytes. Every new elementary-stream packet begins a new transport packet, and its first byte is the first payload byte of that packet. When the final piece is shorter than a full payload, the block places a stuffing field of the exact length needed between the header and the payload, so the packet still ends on its 188-byte boundary.

The input side is a byte stream with valid, ready and an end marker on the last byte of each elementary packet. The first byte seen after reset, or after a byte carrying the end marker, starts a new elementary packet. The block collects up to one payload's worth of bytes. It then sends the complete transport packet out on a byte stream with valid, ready and a start-of-packet flag. A 4-bit continuity counter goes up by one for each packet sent.

Top module: `ts_packetizer`

## Requirements
- R1: After reset, `in_ready` is 1 and `out_valid` is 0, and the first packet sent carries continuity count 0.
- R2: Every output packet is exactly 188 accepted bytes. `out_sop` is 1 on the first byte of each packet and 0 on every other byte.
- R3: Header byte 0 is 0x47. Byte 1 is {error=0, start flag, priority=0, PID[12:8]}. Byte 2 is PID[7:0]. Byte 3 is {scrambling=00, control[1:0], count[3:0]}. The bits are listed MSB first.
- R4: The start flag (byte 1 bit 6) is 1 in the packet that carries the first byte of an elementary packet, and 0 in the packets that follow it.
- R5: A packet with 184 payload bytes has control = 01, and its payload fills bytes 4 to 187 in input order.
- R6: A packet with n ≤ 182 payload bytes has control = 11. Byte 4 is 183−n, byte 5 is 0x00, bytes 6 to 187−n are 0xFF, and the n payload bytes follow in input order.
- R7: A packet with exactly 183 payload bytes has control = 11 and byte 4 = 0x00, with the payload in bytes 5 to 187.
- R8: The continuity count goes up by one with each packet sent and wraps from 15 to 0.
- R9: A transport packet never holds bytes from two elementary packets. The bytes that follow an end marker begin a new packet.
- R10: While `out_valid` is 1 and `out_ready` is 0, `out_valid` stays 1 and `out_data` does not change.
- R11: `in_ready` drops in the cycle after the byte that fills the payload or carries the end marker. It returns to 1 only after the last byte of that packet has been accepted at the output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_data | input | 8 | Elementary-packet byte |
| in_valid | input | 1 | `in_data` is valid |
| in_last | input | 1 | This byte ends the elementary packet |
| in_ready | output | 1 | Block accepts an input byte this cycle |
| out_data | output | 8 | Transport-stream byte |
| out_valid | output | 1 | `out_data` is valid |
| out_ready | input | 1 | Downstream takes the byte this cycle |
| out_sop | output | 1 | First byte of a transport packet |

## Verification
The elementary-packet lengths are chosen to cover each way a packet can close:
- A single byte or two bytes give the longest stuffing field.
- 182 bytes gives the shortest stuffing field that still has a flags byte.
- 183 bytes gives the lone zero-length field.
- 184 bytes gives no field at all.
- 185, 368, 400 and 700 bytes split across packets. Some of them end exactly on a payload boundary, and the others end with a short tail.

Downstream stalls on some patterns show whether stalled bytes are held or lost. Running back-to-back elementary packets tells apart a start flag raised on the right packet from one carried into a continuation packet. Enough packets are sent to walk the continuity count through its wrap. A reset partway through shows that the count is restored to zero.

// File: rtl/ts_pkg.sv
package ts_pkg;
   localparam int unsigned TS_HDR_LEN = 4;
   localparam logic [7:0]  TS_SYNC    = 8'h47;
   localparam logic [7:0]  TS_FILL    = 8'hFF;

   typedef enum logic {
      ST_FILL = 1'b0,
      ST_EMIT = 1'b1
   } ts_state_e;
endpackage

// File: rtl/ts_payload_buf.sv
module ts_payload_buf #(
   parameter int unsigned DEPTH = 184,
   parameter int unsigned CW    = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  logic [7:0]    wr_data,
   input  logic          clr,
   input  logic [CW-1:0] rd_addr,
   output logic [7:0]    rd_data,
   output logic [CW-1:0] fill
);
   localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

   generate
      if (CW < AW) begin : g_bad_width
         $error("ts_payload_buf: count width too small for depth");
      end
   endgenerate

   logic [7:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (wr_en) mem[fill[AW-1:0]] <= wr_data;
   end

   always_ff @(posedge clk) begin
      if (!rst_n || clr) fill <= '0;
      else if (wr_en)    fill <= fill + 1'b1;
   end

   assign rd_data = (rd_addr < CW'(DEPTH)) ? mem[rd_addr[AW-1:0]] : 8'h00;

   // R5
   no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> (fill < CW'(DEPTH)));
endmodule

// File: rtl/ts_byte_mux.sv
module ts_byte_mux
   import ts_pkg::*;
#(
   parameter int unsigned PKT_LEN = 188,
   parameter logic [12:0] PID     = 13'h0100,
   parameter int unsigned CW      = 8
) (
   input  logic [CW-1:0] idx,
   input  logic [CW-1:0] n_pay,
   input  logic          pusi,
   input  logic [3:0]    cc,
   input  logic [7:0]    buf_data,
   output logic [CW-1:0] rd_addr,
   output logic [7:0]    byte_o
);
   localparam int unsigned PAY_MAX = PKT_LEN - TS_HDR_LEN;

   logic [CW-1:0] afl;   // stuffing field size, length byte included
   logic [CW-1:0] off;

   always_comb begin
      afl     = CW'(PAY_MAX) - n_pay;
      off     = idx - CW'(TS_HDR_LEN);
      rd_addr = off - afl;
      byte_o  = TS_FILL;
      if (idx == CW'(0))      byte_o = TS_SYNC;
      else if (idx == CW'(1)) byte_o = {1'b0, pusi, 1'b0, PID[12:8]};
      else if (idx == CW'(2)) byte_o = PID[7:0];
      else if (idx == CW'(3)) byte_o = {2'b00, (afl != '0) ? 2'b11 : 2'b01, cc};
      else if (off < afl) begin
         if (off == CW'(0))      byte_o = 8'(afl - 1'b1);
         else if (off == CW'(1)) byte_o = 8'h00;
         else                    byte_o = TS_FILL;
      end
      else byte_o = buf_data;
   end
endmodule

// File: rtl/ts_packetizer.sv
module ts_packetizer
   import ts_pkg::*;
#(
   parameter int unsigned PKT_LEN = 188,
   parameter logic [12:0] PID     = 13'h0100
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [7:0] in_data,
   input  logic       in_valid,
   input  logic       in_last,
   output logic       in_ready,
   output logic [7:0] out_data,
   output logic       out_valid,
   input  logic       out_ready,
   output logic       out_sop
);
   localparam int unsigned PAY_MAX = PKT_LEN - TS_HDR_LEN;
   localparam int unsigned CW      = $clog2(PKT_LEN + 1);

   generate
      if (PKT_LEN < TS_HDR_LEN + 3) begin : g_bad_len
         $error("ts_packetizer: packet too short for header and stuffing");
      end
      if (PID == 13'h1FFF) begin : g_bad_pid
         $error("ts_packetizer: identifier reserved for null packets");
      end
   endgenerate

   ts_state_e     state;
   logic [CW-1:0] idx, n_hold, fill, rd_addr;
   logic [7:0]    rd_data;
   logic          pusi_q, pes_start;
   logic [3:0]    cc;
   logic          acc, done_pkt;

   assign in_ready  = (state == ST_FILL);
   assign out_valid = (state == ST_EMIT);
   assign out_sop   = out_valid && (idx == '0);
   assign acc       = in_ready && in_valid;
   assign done_pkt  = out_valid && out_ready && (idx == CW'(PKT_LEN - 1));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state     <= ST_FILL;
         idx       <= '0;
         n_hold    <= '0;
         pusi_q    <= 1'b0;
         pes_start <= 1'b1;
         cc        <= 4'd0;
      end else begin
         if (acc) begin
            pes_start <= in_last;
            if (fill == '0) pusi_q <= pes_start;
            if (in_last || fill == CW'(PAY_MAX - 1)) begin
               state  <= ST_EMIT;
               n_hold <= fill + 1'b1;
               idx    <= '0;
            end
         end
         if (out_valid && out_ready) begin
            if (done_pkt) begin
               state <= ST_FILL;
               cc    <= cc + 4'd1;
            end else begin
               idx <= idx + 1'b1;
            end
         end
      end
   end

   ts_payload_buf #(.DEPTH(PAY_MAX), .CW(CW)) buf_i (
      .clk(clk), .rst_n(rst_n), .wr_en(acc), .wr_data(in_data),
      .clr(done_pkt), .rd_addr(rd_addr), .rd_data(rd_data), .fill(fill)
   );

   ts_byte_mux #(.PKT_LEN(PKT_LEN), .PID(PID), .CW(CW)) mux_i (
      .idx(idx), .n_pay(n_hold), .pusi(pusi_q), .cc(cc),
      .buf_data(rd_data), .rd_addr(rd_addr), .byte_o(out_data)
   );

   // R10
   hold_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

   // R2
   sop_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_sop |-> (out_data == TS_SYNC));

   // R11
   ready_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(in_ready) |-> $past(in_valid));

   // R6
   afc_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && idx == CW'(3)) |-> (out_data[5:4] == 2'b01 || out_data[5:4] == 2'b11));
endmodule

// File: tb/ts_packetizer_tb.sv
module ts_packetizer_tb_top;
   localparam logic [12:0] PID = 13'h0100;
   localparam int NV = 9;
   localparam int VLEN [NV] = '{1, 182, 183, 184, 185, 368, 2, 400, 700};
   localparam bit VSTL [NV] = '{0, 1, 0, 1, 0, 1, 0, 0, 1};

   logic clk = 0, rst_n = 0;
   logic [7:0] in_data = 0;
   logic in_valid = 0, in_last = 0, out_ready = 0;
   logic in_ready, out_valid, out_sop;
   logic [7:0] out_data;

   int n_chk = 0, n_bad = 0, cyc = 0, cc_exp = 0;
   logic [7:0] pay [0:1023];
   logic [7:0] got [0:187];
   logic [7:0] expb [0:187];

   always #5 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   ts_packetizer #(.PKT_LEN(188), .PID(PID)) dut_i (
      .clk(clk), .rst_n(rst_n), .in_data(in_data), .in_valid(in_valid),
      .in_last(in_last), .in_ready(in_ready), .out_data(out_data),
      .out_valid(out_valid), .out_ready(out_ready), .out_sop(out_sop)
   );

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic fill_pay(input int len, input int seed);
      for (int i = 0; i < len; i++) pay[i] = 8'(seed * 29 + i * 7 + 1);
   endtask

   task automatic send_pes(input int len);
      for (int i = 0; i < len; i++) begin
         bit a;
         in_valid = 1; in_data = pay[i]; in_last = (i == len - 1);
         do begin a = in_ready; @(negedge clk); end while (!a);
      end
      in_valid = 0; in_last = 0;
   endtask

   task automatic recv_pes(input int len, input bit stall);
      int npk, n, afl, k, bad_at;
      bit sop_bad, stab_bad, pend;
      logic [7:0] held;
      string ftag;
      npk = (len + 183) / 184;
      for (int p = 0; p < npk; p++) begin
         n = len - p * 184; if (n > 184) n = 184;
         afl = 184 - n;
         expb[0] = 8'h47;
         expb[1] = {1'b0, (p == 0), 1'b0, PID[12:8]};
         expb[2] = PID[7:0];
         expb[3] = {2'b00, (afl != 0) ? 2'b11 : 2'b01, 4'(cc_exp)};
         if (afl >= 1) expb[4] = 8'(afl - 1);
         if (afl >= 2) expb[5] = 8'h00;
         for (int j = 6; j < 4 + afl; j++) expb[j] = 8'hFF;
         for (int j = 0; j < n; j++) expb[4 + afl + j] = pay[p * 184 + j];
         k = 0; sop_bad = 0; stab_bad = 0; pend = 0; held = 0;
         while (k < 188) begin
            out_ready = stall ? (cyc % 3 != 2) : 1'b1;
            if (pend && (!out_valid || out_data != held)) stab_bad = 1;
            pend = out_valid && !out_ready; held = out_data;
            if (out_valid && out_ready) begin
               got[k] = out_data;
               if (out_sop != (k == 0)) sop_bad = 1;
               k++;
            end
            @(negedge clk);
         end
         out_ready = 0;
         chk(!sop_bad, "R2 sop placement", sop_bad, 0);
         chk(!stab_bad, "R10 stall hold", stab_bad, 0);
         chk(got[0] == 8'h47 && got[2] == expb[2], "R3 sync/pid", {got[0], got[2]}, {expb[0], expb[2]});
         chk(got[1] == expb[1], "R4 start flag byte", got[1], expb[1]);
         chk(got[3][3:0] == expb[3][3:0], "R8 count", got[3][3:0], expb[3][3:0]);
         ftag = (n == 184) ? "R5 field" : (n == 183) ? "R7 field" : "R6 field";
         bad_at = -1;
         for (int j = 3; j < 4 + afl; j++) if (bad_at < 0 && got[j] != expb[j]) bad_at = j;
         chk(bad_at < 0, ftag, (bad_at < 0) ? 0 : got[bad_at], (bad_at < 0) ? 0 : expb[bad_at]);
         bad_at = -1;
         for (int j = 4 + afl; j < 188; j++) if (bad_at < 0 && got[j] != expb[j]) bad_at = j;
         chk(bad_at < 0, "R9 payload bytes", (bad_at < 0) ? 0 : got[bad_at], (bad_at < 0) ? 0 : expb[bad_at]);
         cc_exp = (cc_exp + 1) % 16;
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      // R1 reset state
      chk(in_ready && !out_valid, "R1 reset handshake", {in_ready, out_valid}, 2);

      for (int v = 0; v < NV; v++) begin
         fill_pay(VLEN[v], v);
         fork
            send_pes(VLEN[v]);
            recv_pes(VLEN[v], VSTL[v]);
         join
      end
      // R8 wrap: 16 packets above, count back at 0
      chk(cc_exp == 0, "R8 wrap reached", cc_exp, 0);

      // R11 / R10 directed: downstream held off
      fill_pay(3, 40);
      out_ready = 0;
      send_pes(3);
      chk(!in_ready && out_valid, "R11 in_ready low while sending", {in_ready, out_valid}, 1);
      repeat (4) @(negedge clk);
      chk(out_valid && out_sop && out_data == 8'h47, "R10 held first byte", out_data, 8'h47);
      recv_pes(3, 0);
      chk(in_ready, "R11 in_ready back", in_ready, 1);

      // R1 reset mid-run restores count
      rst_n = 0;
      repeat (2) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      chk(in_ready && !out_valid, "R1 reset again", {in_ready, out_valid}, 2);
      cc_exp = 0;
      fill_pay(5, 41);
      fork
         send_pes(5);
         recv_pes(5, 1);
      join

      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule